// File: doc/BRIEF.md
# Segmented waveform playback controller

This block walks addresses through a 1024-word by 32-bit waveform memory and passes each word it reads to one of two downstream consumers. Two segment profiles are held on chip. Each profile sets a first address, a last address, a pacing divider and a traversal mode. An edge on the trigger input starts playback, and the direction of that edge chooses the profile: a rising edge selects profile 0 and a falling edge selects profile 1.

Each memory word holds an I sample in bits 31:16 and a Q sample in bits 15:0. The samples go to one of two destinations:
- The signed baseband path receives 18-bit values. Each 16-bit two's-complement sample is placed in the top 16 bits, and its sign bit is copied into the two low bits.
- The scaling-factor path receives the unsigned 16-bit fractions unchanged.

Software writes profile and control fields into shadow registers through a small register port. An update strobe copies all shadow fields into the working set at once. Playback advances only on cycles where the playback clock enable is high.

Top module: `seg_wave_player`

## Requirements
- R1: Writes through the register port land in shadow storage. The working profiles, enable and destination change only on the clock edge where `cfg_update` is high. Register map:
  - address 0: profile 0, first address in bits 9:0, last address in bits 25:16.
  - address 1: profile 0, pacing divider in bits 15:0, mode in bits 18:16.
  - addresses 2 and 3: the same layout for profile 1.
  - address 4: control, enable in bit 0 and destination in bit 1 (1 = baseband, 0 = scaling).
- R2: While enabled, a 0-to-1 change on `trig` starts playback from profile 0, and a 1-to-0 change starts it from profile 1. A new edge restarts playback even when playback is already running.
- R3: Mode 0 reads from the first address up to the last address, then keeps reading the last address.
- R4: Mode 1 reads from the last address down to the first address, then keeps reading the first address.
- R5: Mode 2 reads from the first address up to the last address and then jumps back to the first address, repeating without end.
- R6: Mode 3 reads up to the last address, then down to the first address, and repeats. Each turning address is read once per turn.
- R7: Mode codes 4 to 7 start no playback and do not raise `cfg_err`.
- R8: In scaling mode, each address is read on D consecutive cycles where `pb_ce` is high, D being the pacing divider. A divider of 0 behaves as 1. Cycles where `pb_ce` is low perform no read and do not advance playback.
- R9: A start whose profile has a last address less than or equal to its first address sets `cfg_err` and leaves playback stopped. The next start with a valid profile clears `cfg_err`.
- R10: When the baseband destination is selected, `bb_i`/`bb_q` receive the I/Q sample with its sign bit copied into bits 1:0, and `bb_vld` marks them. When the scaling destination is selected, `sc_i`/`sc_q` receive the samples unchanged, and `sc_vld` marks them. The two valid signals are never high together.
- R11: With the baseband destination selected, the pacing divider is ignored and the address moves on every enabled cycle. `par_en` is low exactly when playback is enabled and the baseband destination is selected.
- R12: While the working enable is 0, trigger edges are ignored and no memory read is issued. Clearing the enable stops a running playback.
- R13: When a trigger edge is sampled on clock edge N and `pb_ce` is high, the first memory read is issued in the cycle after N, and its sample appears on the outputs after clock edge N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| cfg_update | input | 1 | Copies shadow registers into the working set |
| trig | input | 1 | Playback trigger level; edges start playback |
| pb_ce | input | 1 | Playback clock enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 10 | Memory read address |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd` |
| bb_i | output | 18 | Baseband I sample |
| bb_q | output | 18 | Baseband Q sample |
| bb_vld | output | 1 | Baseband sample pair valid |
| sc_i | output | 16 | Scaling-factor I value |
| sc_q | output | 16 | Scaling-factor Q value |
| sc_vld | output | 1 | Scaling pair valid |
| par_en | output | 1 | External parallel data path allowed |
| cfg_err | output | 1 | Last start attempt had an invalid address range |

## Verification
A trigger change that is sampled on edge N puts the sequencer into its running state on that edge. The memory captures the first word on edge N+1, and the output registers load it on edge N+2. The bench therefore drives inputs 2 ns after a rising edge and expects the first logged sample three edges after the cycle in which it drove the trigger. A monitor runs on falling edges and stamps every valid sample with its cycle number. It decodes the address from the data, because the bench's memory model encodes the address into each word. Each scenario then compares this logged sequence with an expected sequence, computed in closed form from the mode, bounds and divider. Because the comparison is on the sequence and not on absolute cycles, the checks do not depend on pipeline depth. Latency is checked once, directly, and `pb_ce` stalls are checked through the spacing of the cycle stamps.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int ADDR_W = 10;
  localparam int SAMP_W = 16;
  localparam int WORD_W = 2 * SAMP_W;
  localparam int BB_W   = 18;
  localparam int STEP_W = 16;
  localparam int MODE_W = 3;
  localparam int NSEG   = 2;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;
  localparam int HI_LSB = 16;
  localparam int CTL_IX = 2 * NSEG;

  typedef enum logic [MODE_W-1:0] {
    PM_RAMP_UP = 3'd0,
    PM_RAMP_DN = 3'd1,
    PM_LOOP    = 3'd2,
    PM_BOUNCE  = 3'd3
  } pmode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_HOLD = 2'd2
  } sq_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] first;
    logic [ADDR_W-1:0] last;
    logic [STEP_W-1:0] rate;
    logic [MODE_W-1:0] mode;
  } seg_cfg_t;

  // Sign-extend downward: sample in the top bits, sign copies below.
  function automatic logic [BB_W-1:0] to_baseband(input logic [SAMP_W-1:0] s);
    return {s, {(BB_W - SAMP_W){s[SAMP_W-1]}}};
  endfunction

  // Down-counter reload: divider minus one; zero and baseband force one.
  function automatic logic [STEP_W-1:0] reload_of(input logic [STEP_W-1:0] rate,
                                                  input logic force_one);
    if (force_one || rate == '0) return '0;
    return rate - 1'b1;
  endfunction

  function automatic logic range_bad(input seg_cfg_t c);
    return c.last <= c.first;
  endfunction

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return m <= MODE_W'(3);
  endfunction
endpackage

// File: rtl/swp_regs.sv
module swp_regs
  import swp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [REG_AW-1:0]       wr_addr,
  input  logic [REG_DW-1:0]       wr_data,
  input  logic                    upd,
  output seg_cfg_t [NSEG-1:0]     act_seg,
  output logic                    act_en,
  output logic                    act_bb
);
  logic shd_en, shd_bb;
  logic unused_hi;
  assign unused_hi = ^wr_data[REG_DW-1:HI_LSB+ADDR_W];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    seg_cfg_t shd_q, act_q;
    logic hit_lim, hit_pace;
    assign hit_lim  = wr_en && (wr_addr == REG_AW'(2 * g));
    assign hit_pace = wr_en && (wr_addr == REG_AW'(2 * g + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= '0;
      end else if (hit_lim) begin
        shd_q.first <= wr_data[ADDR_W-1:0];
        shd_q.last  <= wr_data[HI_LSB +: ADDR_W];
      end else if (hit_pace) begin
        shd_q.rate <= wr_data[STEP_W-1:0];
        shd_q.mode <= wr_data[HI_LSB +: MODE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   act_q <= '0;
      else if (upd) act_q <= shd_q;
    end

    assign act_seg[g] = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_en <= 1'b0;
      shd_bb <= 1'b0;
    end else if (wr_en && wr_addr == REG_AW'(CTL_IX)) begin
      shd_en <= wr_data[0];
      shd_bb <= wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en <= 1'b0;
      act_bb <= 1'b0;
    end else if (upd) begin
      act_en <= shd_en;
      act_bb <= shd_bb;
    end
  end

  AST_NO_CHANGE_WITHOUT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(act_en) && $stable(act_bb) && $stable(act_seg)) else $error("working set moved"); // R1
endmodule

// File: rtl/swp_seq.sv
module swp_seq
  import swp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig,
  input  logic                pb_ce,
  input  logic                en,
  input  logic                bb,
  input  seg_cfg_t [NSEG-1:0] seg,
  output logic                mem_rd,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                cfg_err
);
  logic              trig_q;
  logic              ev_rise, ev_fall, ev_kick, ev_tick, ev_adv;
  logic              at_first, at_last;
  seg_cfg_t          pick, cur;
  sq_state_e         st;
  logic [ADDR_W-1:0] addr, nxt_addr;
  logic              up, nxt_up, nxt_hold;
  logic [STEP_W-1:0] cnt;

  // Edge events: direction selects the profile.
  assign ev_rise = trig & ~trig_q;
  assign ev_fall = ~trig & trig_q;
  assign ev_kick = en & (ev_rise | ev_fall);
  assign pick    = ev_fall ? seg[1] : seg[0];

  assign ev_tick  = en & pb_ce & (st == SQ_RUN) & ~ev_kick;
  assign ev_adv   = ev_tick & (cnt == '0);
  assign at_first = (addr == cur.first);
  assign at_last  = (addr == cur.last);

  always_comb begin
    nxt_addr = addr;
    nxt_up   = up;
    nxt_hold = 1'b0;
    case (cur.mode)
      PM_RAMP_UP: begin
        if (at_last) nxt_hold = 1'b1;
        else         nxt_addr = addr + 1'b1;
      end
      PM_RAMP_DN: begin
        if (at_first) nxt_hold = 1'b1;
        else          nxt_addr = addr - 1'b1;
      end
      PM_LOOP: nxt_addr = at_last ? cur.first : addr + 1'b1;
      PM_BOUNCE: begin
        if (up) begin
          if (at_last) begin nxt_up = 1'b0; nxt_addr = addr - 1'b1; end
          else         nxt_addr = addr + 1'b1;
        end else begin
          if (at_first) begin nxt_up = 1'b1; nxt_addr = addr + 1'b1; end
          else          nxt_addr = addr - 1'b1;
        end
      end
      default: nxt_hold = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      st      <= SQ_IDLE;
      cur     <= '0;
      addr    <= '0;
      up      <= 1'b1;
      cnt     <= '0;
      cfg_err <= 1'b0;
    end else begin
      trig_q <= trig;
      if (ev_kick) begin
        cur     <= pick;
        cnt     <= reload_of(pick.rate, bb);
        up      <= (pick.mode != PM_RAMP_DN);
        addr    <= (pick.mode == PM_RAMP_DN) ? pick.last : pick.first;
        cfg_err <= range_bad(pick);
        st      <= (!range_bad(pick) && mode_known(pick.mode)) ? SQ_RUN : SQ_IDLE;
      end else if (!en) begin
        st <= SQ_IDLE;
      end else if (ev_tick) begin
        if (!ev_adv) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt  <= reload_of(cur.rate, bb);
          addr <= nxt_addr;
          up   <= nxt_up;
          if (nxt_hold) st <= SQ_HOLD;
        end
      end
    end
  end

  assign mem_rd   = en & pb_ce & (st != SQ_IDLE);
  assign mem_addr = addr;

  AST_ADDR_IN_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SQ_IDLE) |-> (addr >= cur.first && addr <= cur.last)) else $error("address left segment"); // R5
  AST_FALL_PICKS_SEG1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kick && ev_fall) |=> (cur == $past(seg[1]))) else $error("wrong profile on fall"); // R2
  AST_BAD_RANGE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kick && range_bad(pick)) |=> (st == SQ_IDLE && cfg_err)) else $error("bad range ran"); // R9
  AST_IDLE_MODE_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kick && !mode_known(pick.mode)) |=> (st == SQ_IDLE)) else $error("idle code ran"); // R7
  AST_DIVIDER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tick && !ev_adv) |=> $stable(addr)) else $error("address moved early"); // R8
  AST_CE_LOW_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_RUN && en && !pb_ce && !ev_kick) |=> ($stable(addr) && $stable(cnt))) else $error("stall broken"); // R8
  AST_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == SQ_IDLE)) else $error("ran while disabled"); // R12
endmodule

// File: rtl/swp_fmt.sv
module swp_fmt
  import swp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [WORD_W-1:0] rdata,
  input  logic              bb,
  output logic [BB_W-1:0]   bb_i,
  output logic [BB_W-1:0]   bb_q,
  output logic              bb_vld,
  output logic [SAMP_W-1:0] sc_i,
  output logic [SAMP_W-1:0] sc_q,
  output logic              sc_vld
);
  logic              rd_q;
  logic [SAMP_W-1:0] s_i, s_q;
  assign s_i = rdata[WORD_W-1 -: SAMP_W];
  assign s_q = rdata[SAMP_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      bb_i   <= '0;
      bb_q   <= '0;
      sc_i   <= '0;
      sc_q   <= '0;
      bb_vld <= 1'b0;
      sc_vld <= 1'b0;
    end else begin
      rd_q   <= rd;
      bb_vld <= rd_q & bb;
      sc_vld <= rd_q & ~bb;
      if (rd_q && bb) begin
        bb_i <= to_baseband(s_i);
        bb_q <= to_baseband(s_q);
      end
      if (rd_q && !bb) begin
        sc_i <= s_i;
        sc_q <= s_q;
      end
    end
  end

  AST_ONE_PATH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(bb_vld && sc_vld)) else $error("both paths valid"); // R10
  AST_BB_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    bb_vld |-> (bb_i[1:0] == {2{bb_i[BB_W-1]}} && bb_q[1:0] == {2{bb_q[BB_W-1]}})) else $error("sign fill"); // R10
  AST_SC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && !bb) |=> (sc_i == $past(s_i) && sc_q == $past(s_q))) else $error("scaling word altered"); // R10
endmodule

// File: rtl/seg_wave_player.sv
module seg_wave_player
  import swp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              cfg_update,
  input  logic              trig,
  input  logic              pb_ce,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [BB_W-1:0]   bb_i,
  output logic [BB_W-1:0]   bb_q,
  output logic              bb_vld,
  output logic [SAMP_W-1:0] sc_i,
  output logic [SAMP_W-1:0] sc_q,
  output logic              sc_vld,
  output logic              par_en,
  output logic              cfg_err
);
  seg_cfg_t [NSEG-1:0] act_seg;
  logic                act_en, act_bb;

  swp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .upd(cfg_update), .act_seg(act_seg),
    .act_en(act_en), .act_bb(act_bb)
  );

  swp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .pb_ce(pb_ce), .en(act_en),
    .bb(act_bb), .seg(act_seg), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .cfg_err(cfg_err)
  );

  swp_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .rd(mem_rd), .rdata(mem_rdata), .bb(act_bb),
    .bb_i(bb_i), .bb_q(bb_q), .bb_vld(bb_vld), .sc_i(sc_i), .sc_q(sc_q),
    .sc_vld(sc_vld)
  );

  assign par_en = ~(act_en & act_bb);

  AST_READ_TO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ##1 (bb_vld || sc_vld)) else $error("read produced no sample"); // R13
endmodule

// File: tb/seg_wave_player_tb.sv
module seg_wave_player_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        cfg_update = 1'b0;
  logic        trig = 1'b0;
  logic        pb_ce = 1'b1;
  logic        mem_rd;
  logic [9:0]  mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [17:0] bb_i, bb_q;
  logic        bb_vld, sc_vld, par_en, cfg_err;
  logic [15:0] sc_i, sc_q;

  int  n_chk = 0, n_bad = 0;
  int  cyc = 0;
  int  epoch = 0;
  bit  ce_alt = 1'b0;
  bit  wd_hit = 1'b0;

  // monitor-owned state
  int  lg_a[256];
  int  lg_c[256];
  int  lg_n = 0, lg_bb = 0, lg_sc = 0, seen_epoch = 0;
  int  mon_chk = 0, mon_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seg_wave_player u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_update(cfg_update), .trig(trig), .pb_ce(pb_ce),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bb_i(bb_i), .bb_q(bb_q), .bb_vld(bb_vld), .sc_i(sc_i), .sc_q(sc_q),
    .sc_vld(sc_vld), .par_en(par_en), .cfg_err(cfg_err)
  );

  // Memory model: the address is folded into both halves of each word.
  function automatic logic [31:0] ram_word(input int a);
    logic [9:0] x;
    x = 10'(a);
    return {x, 6'b101011, ~x, 6'b010100};
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= ram_word(int'(mem_addr));

  // Sample monitor on falling edges; checks data format per sample (R10).
  always @(negedge clk) begin : mon
    logic [9:0]  a;
    logic [31:0] w;
    logic [17:0] ei, eq;
    if (epoch != seen_epoch) begin
      seen_epoch = epoch;
      lg_n = 0; lg_bb = 0; lg_sc = 0;
    end
    if (bb_vld && sc_vld) begin
      mon_chk++; mon_bad++;
      $display("FAIL R10 both valids high: actual=1 expected=0");
    end
    if (sc_vld || bb_vld) begin
      a = sc_vld ? sc_i[15:6] : bb_i[17:8];
      w = ram_word(int'(a));
      mon_chk++;
      if (sc_vld) begin
        lg_sc++;
        if (sc_i != w[31:16] || sc_q != w[15:0]) begin
          mon_bad++;
          $display("FAIL R10 scaling word: actual=%h%h expected=%h", sc_i, sc_q, w);
        end
      end else begin
        lg_bb++;
        ei = {w[31:16], w[31], w[31]};
        eq = {w[15:0], w[15], w[15]};
        if (bb_i != ei || bb_q != eq) begin
          mon_bad++;
          $display("FAIL R10 baseband word: actual=%h/%h expected=%h/%h", bb_i, bb_q, ei, eq);
        end
      end
      if (lg_n < 256) begin
        lg_a[lg_n] = int'(a);
        lg_c[lg_n] = cyc;
        lg_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic commit();
    cfg_update = 1'b1; tick(1); cfg_update = 1'b0;
  endtask

  task automatic set_seg(input int s, input int first, input int last,
                         input int rate, input int mode, input bit do_upd);
    wreg(2 * s,     {6'd0, 10'(last), 6'd0, 10'(first)});
    wreg(2 * s + 1, {13'd0, 3'(mode), 16'(rate)});
    if (do_upd) commit();
  endtask

  task automatic set_ctl(input bit en, input bit bb);
    wreg(4, {30'd0, bb, en});
    commit();
  endtask

  // Stop playback, park trigger at the given level, drain, clear the log.
  task automatic quiesce(input bit lvl);
    set_ctl(1'b0, 1'b0);
    trig = lvl;
    tick(6);
    epoch++;
    tick(1);
  endtask

  task automatic fire(output int t0);
    trig = ~trig;
    t0 = cyc;
  endtask

  // Closed-form expected address for the k-th read.
  function automatic int exp_addr(input int mode, input int first, input int last,
                                  input int rate, input int bbm, input int k);
    int r, span, s, p;
    r    = (bbm != 0 || rate == 0) ? 1 : rate;
    span = last - first;
    s    = k / r;
    p    = 0;
    case (mode)
      0: return first + ((s < span) ? s : span);
      1: return last - ((s < span) ? s : span);
      2: return first + (s % (span + 1));
      3: begin
        p = s % (2 * span);
        return (p <= span) ? first + p : last - (p - span);
      end
      default: return -1;
    endcase
  endfunction

  task automatic cmp_seq(input string req, input int mode, input int first,
                         input int last, input int rate, input int bbm, input int cnt);
    int bad_k, bad_a, bad_e;
    chk(lg_n >= cnt, req, "sample count", lg_n, cnt);
    bad_k = -1; bad_a = 0; bad_e = 0;
    for (int k = 0; k < cnt && k < lg_n; k++) begin
      if (bad_k < 0 && lg_a[k] != exp_addr(mode, first, last, rate, bbm, k)) begin
        bad_k = k; bad_a = lg_a[k]; bad_e = exp_addr(mode, first, last, rate, bbm, k);
      end
    end
    chk(bad_k < 0, req, $sformatf("address sequence at read %0d", bad_k), bad_a, bad_e);
  endtask

  task automatic t_reset();
    chk(mem_rd == 1'b0, "R12", "mem_rd after reset", mem_rd, 0);
    chk(!bb_vld && !sc_vld, "R10", "valids after reset", {bb_vld, sc_vld}, 0);
    chk(par_en == 1'b1, "R11", "par_en after reset", par_en, 1);
    chk(cfg_err == 1'b0, "R9", "cfg_err after reset", cfg_err, 0);
  endtask

  task automatic t_ramp_up();
    int t0;
    set_seg(0, 10, 14, 1, 0, 1'b1);
    quiesce(1'b0);
    set_ctl(1'b1, 1'b0);
    fire(t0);
    tick(20);
    chk(lg_n > 0 && lg_c[0] == t0 + 3, "R13", "first sample cycle", lg_c[0], t0 + 3);
    cmp_seq("R3", 0, 10, 14, 1, 0, 12);
  endtask

  task automatic t_fall_ramp_down();
    int t0;
    set_seg(1, 40, 45, 2, 1, 1'b1);
    quiesce(1'b1);
    set_ctl(1'b1, 1'b0);
    fire(t0);
    tick(24);
    chk(lg_n > 0 && lg_a[0] == 45, "R2", "falling edge uses profile 1", lg_a[0], 45);
    cmp_seq("R4", 1, 40, 45, 2, 0, 16);
  endtask

  task automatic t_loop();
    int t0;
    set_seg(0, 100, 103, 3, 2, 1'b1);
    quiesce(1'b0);
    set_ctl(1'b1, 1'b0);
    fire(t0);
    tick(40);
    cmp_seq("R5", 2, 100, 103, 3, 0, 30);
  endtask

  task automatic t_bounce();
    int t0;
    set_seg(0, 200, 204, 1, 3, 1'b1);
    quiesce(1'b0);
    set_ctl(1'b1, 1'b0);
    fire(t0);
    tick(30);
    cmp_seq("R6", 3, 200, 204, 1, 0, 20);
  endtask

  task automatic t_rate_zero();
    int t0;
    set_seg(1, 300, 302, 0, 2, 1'b1);
    quiesce(1'b1);
    set_ctl(1'b1, 1'b0);
    fire(t0);
    tick(16);
    cmp_seq("R8", 2, 300, 302, 1, 0, 9);
  endtask

  task automatic t_stall();
    int t0;
    set_seg(0, 500, 509, 2, 0, 1'b1);
    quiesce(1'b0);
    set_ctl(1'b1, 1'b0);
    ce_alt = 1'b1;
    fire(t0);
    tick(60);
    ce_alt = 1'b0;
    chk(lg_n > 1 && lg_c[1] - lg_c[0] == 2, "R8", "read spacing with pb_ce alternating",
        lg_c[1] - lg_c[0], 2);
    cmp_seq("R8", 0, 500, 509, 2, 0, 24);
  endtask

  task automatic t_shadow();
    int t0;
    set_seg(0, 10, 14, 1, 0, 1'b1);
    quiesce(1'b0);
    set_ctl(1'b1, 1'b0);
    set_seg(0, 600, 605, 1, 0, 1'b0);
    fire(t0);
    tick(16);
    cmp_seq("R1", 0, 10, 14, 1, 0, 8);
    wreg(4, 32'd0);
    epoch++;
    tick(10);
    chk(lg_n > 0, "R1", "uncommitted disable keeps playback", lg_n, 1);
    quiesce(1'b0);
    set_ctl(1'b1, 1'b0);
    fire(t0);
    tick(16);
    cmp_seq("R1", 0, 600, 605, 1, 0, 8);
  endtask

  task automatic t_bad_range();
    int t0;
    set_seg(1, 700, 700, 1, 0, 1'b1);
    quiesce(1'b1);
    set_ctl(1'b1, 1'b0);
    fire(t0);
    tick(10);
    chk(cfg_err == 1'b1, "R9", "cfg_err on equal bounds", cfg_err, 1);
    chk(lg_n == 0, "R9", "samples after bad start", lg_n, 0);
    set_seg(0, 20, 23, 1, 2, 1'b1);
    fire(t0);
    tick(10);
    chk(cfg_err == 1'b0, "R9", "cfg_err after valid start", cfg_err, 0);
    chk(lg_n > 0 && lg_a[0] == 20, "R9", "valid start plays", lg_a[0], 20);
  endtask

  task automatic t_idle_mode();
    int t0;
    set_seg(0, 10, 14, 1, 5, 1'b1);
    quiesce(1'b0);
    set_ctl(1'b1, 1'b0);
    fire(t0);
    tick(10);
    chk(lg_n == 0, "R7", "samples for mode 5", lg_n, 0);
    chk(cfg_err == 1'b0, "R7", "cfg_err for mode 5", cfg_err, 0);
  endtask

  task automatic t_disabled();
    int t0;
    set_seg(0, 30, 35, 1, 2, 1'b1);
    quiesce(1'b0);
    fire(t0);
    tick(2);
    chk(mem_rd == 1'b0, "R12", "mem_rd while disabled", mem_rd, 0);
    tick(8);
    chk(lg_n == 0, "R12", "samples while disabled", lg_n, 0);
  endtask

  task automatic t_baseband();
    int t0;
    set_seg(0, 800, 803, 5, 2, 1'b1);
    quiesce(1'b0);
    set_ctl(1'b1, 1'b1);
    chk(par_en == 1'b0, "R11", "par_en with baseband", par_en, 0);
    fire(t0);
    tick(20);
    cmp_seq("R11", 2, 800, 803, 5, 1, 12);
    chk(lg_bb > 0 && lg_sc == 0, "R10", "baseband-only samples", lg_sc, 0);
    set_ctl(1'b1, 1'b0);
    chk(par_en == 1'b1, "R11", "par_en with scaling", par_en, 1);
  endtask

  task automatic run_all();
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_ramp_up();
    t_fall_ramp_down();
    t_loop();
    t_bounce();
    t_rate_zero();
    t_stall();
    t_shadow();
    t_bad_range();
    t_idle_mode();
    t_disabled();
    t_baseband();
    tick(4);
  endtask

  initial begin
    fork
      forever begin
        @(negedge clk);
        pb_ce = ce_alt ? ~pb_ce : 1'b1;
      end
    join_none
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) chk(1'b0, "R13", "watchdog expired", 1, 0);
    n_chk += mon_chk;
    n_bad += mon_bad;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule